// File: doc/BRIEF.md
# Non-posted request error responder

This block answers non-posted requests that cannot be serviced on the receive side of a packet link device. Upstream logic has already decoded each request into a command code, a dword count, a source tag and two failure flags. One flag says the addressed target could not complete the work. The other says this device sits at the end of the chain and nobody claimed the address. For a failing non-posted request the block builds the matching response and streams it out over a valid/ready channel. A response is a header beat, followed by filler data beats when the request expected data back.

Requests that return data are always answered with the full data length, even though the data is meaningless. This lets every buffer along the return path release its reservation. The two kinds of failure are told apart in the header's error flags and in the filler value. Posted requests, and requests with neither failure flag, are consumed silently because a different path services them. One response is in flight at a time. A new request waits on its ready signal until the current response has fully drained.

Top module: `errrsp_top`

## Requirements
- R1: A failing sized read (command code 2) or atomic read-modify-write (code 3) is answered with a header of kind 0 (read response), followed by exactly n+1 data beats, where n is the value on `req_count`.
- R2: A failing non-posted sized write (code 1) or flush (code 4) is answered with a header of kind 1 (target done) only. That header carries `rsp_last` = 1.
- R3: When only the target-failure flag is set, the header carries `rsp_err` = 1 and `rsp_nxa` = 0, and every data beat is all zeros.
- R4: When the no-claimant flag is set, whatever the target-failure flag holds, the header carries `rsp_err` = 1 and `rsp_nxa` = 1.
- R5: The number of data beats does not depend on how `rsp_ready` is throttled. No beat is skipped or repeated.
- R6: Every data beat of a no-claimant response is all ones.
- R7: `rsp_tag` equals the tag of the request being answered, on every beat of its response.
- R8: The header (`rsp_hdr` = 1) is the first beat. `rsp_last` is 1 on the final beat only. While `rsp_valid` = 1 and `rsp_ready` = 0, all response outputs hold their values.
- R9: A posted write (code 0), a reserved code (5 to 7), or a request with both failure flags clear is accepted and yields no response.
- R10: While a response is in flight, `req_ready` is 0. A waiting request is never lost: it is accepted the cycle after the final beat is taken, and then answered.
- R11: After reset, `rsp_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request fields are valid |
| req_ready | output | 1 | Block can take a request |
| req_cmd | input | 3 | Command code (0 posted write, 1 non-posted write, 2 sized read, 3 atomic, 4 flush) |
| req_count | input | CNT_W | Requested dwords minus one |
| req_tag | input | TAG_W | Source tag of the request |
| req_tgt_fail | input | 1 | Target could not complete the request |
| req_no_claim | input | 1 | End-of-chain device found no claimant |
| rsp_valid | output | 1 | Response beat is valid |
| rsp_ready | input | 1 | Receiver takes the beat |
| rsp_hdr | output | 1 | Beat is the response header |
| rsp_kind | output | 1 | 0 read response, 1 target done |
| rsp_err | output | 1 | Error flag of the response |
| rsp_nxa | output | 1 | Non-existent-address flag of the response |
| rsp_tag | output | TAG_W | Tag copied from the request |
| rsp_data | output | DATA_W | Filler data (zero on the header beat) |
| rsp_last | output | 1 | Final beat of the response |

## Verification
Two functions can fall in the same cycle: the final beat of one response being taken, and a fresh request waiting at the input. The bench holds a second request on `req_valid` while the first response drains under a stuttering `rsp_ready`. At every sampled point of that first response it checks that `req_ready` stays low. It then checks that the second request comes out afterwards with its own tag, flags and full beat count. This shows that the waiting request was neither dropped nor merged into the tail of the first response.

// File: rtl/errrsp_pkg.sv
package errrsp_pkg;
  localparam logic [2:0] CMD_WR_POSTED = 3'd0;
  localparam logic [2:0] CMD_WR_NP     = 3'd1;
  localparam logic [2:0] CMD_RD_SIZED  = 3'd2;
  localparam logic [2:0] CMD_ATOMIC    = 3'd3;
  localparam logic [2:0] CMD_FLUSH     = 3'd4;

  localparam logic KIND_READ = 1'b0;
  localparam logic KIND_DONE = 1'b1;

  typedef struct packed {
    logic need;      // a response must be produced
    logic has_data;  // response carries data beats
    logic nxa;       // no claimant: error + nxa
  } job_t;
endpackage

// File: rtl/errrsp_classify.sv
module errrsp_classify
  import errrsp_pkg::*;
(
  input  logic [2:0] cmd,
  input  logic       tgt_fail,
  input  logic       no_claim,
  output job_t       job
);
  logic failed;
  assign failed = tgt_fail | no_claim;

  always_comb begin
    job.nxa = no_claim;
    case (cmd)
      CMD_RD_SIZED, CMD_ATOMIC: begin
        job.need     = failed;
        job.has_data = 1'b1;
      end
      CMD_WR_NP, CMD_FLUSH: begin
        job.need     = failed;
        job.has_data = 1'b0;
      end
      default: begin
        job.need     = 1'b0;
        job.has_data = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/errrsp_filler.sv
module errrsp_filler #(
  parameter int DATA_W = 32
) (
  input  logic              nxa,
  output logic [DATA_W-1:0] fill
);
  localparam int NBYTES = DATA_W / 8;

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    assign fill[g*8 +: 8] = {8{nxa}};
  end
endmodule

// File: rtl/errrsp_sequencer.sv
module errrsp_sequencer
  import errrsp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 4,
  parameter int TAG_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  job_t              job_in,
  input  logic [CNT_W-1:0]  count_in,
  input  logic [TAG_W-1:0]  tag_in,
  input  logic [DATA_W-1:0] fill_in,
  output logic              idle,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hdr,
  output logic              rsp_kind,
  output logic              rsp_err,
  output logic              rsp_nxa,
  output logic [TAG_W-1:0]  rsp_tag,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_last
);
  logic              busy_q;
  logic              hdr_q;
  logic              data_q;
  logic              nxa_q;
  logic [CNT_W-1:0]  rem_q;
  logic [TAG_W-1:0]  tag_q;
  logic [DATA_W-1:0] fill_q;
  logic              take;

  assign take = busy_q & rsp_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      hdr_q  <= 1'b0;
      data_q <= 1'b0;
      nxa_q  <= 1'b0;
      rem_q  <= '0;
      tag_q  <= '0;
      fill_q <= '0;
    end else if (!busy_q) begin
      if (load && job_in.need) begin
        busy_q <= 1'b1;
        hdr_q  <= 1'b1;
        data_q <= job_in.has_data;
        nxa_q  <= job_in.nxa;
        rem_q  <= count_in;
        tag_q  <= tag_in;
        fill_q <= fill_in;
      end
    end else if (take) begin
      if (hdr_q) begin
        hdr_q <= 1'b0;
        if (!data_q) busy_q <= 1'b0;
      end else if (rem_q == '0) begin
        busy_q <= 1'b0;
      end else begin
        rem_q <= rem_q - 1'b1;
      end
    end
  end

  assign idle      = ~busy_q;
  assign rsp_valid = busy_q;
  assign rsp_hdr   = busy_q & hdr_q;
  assign rsp_kind  = data_q ? KIND_READ : KIND_DONE;
  assign rsp_err   = busy_q;
  assign rsp_nxa   = nxa_q;
  assign rsp_tag   = tag_q;
  assign rsp_data  = hdr_q ? '0 : fill_q;
  assign rsp_last  = busy_q & (hdr_q ? ~data_q : (rem_q == '0));

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_tag)
      && $stable(rsp_hdr) && $stable(rsp_last) && $stable(rsp_nxa)); // R8
  AST_ERR_SET: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> rsp_err); // R3
  AST_NXA_FILL: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_nxa && !rsp_hdr |-> (rsp_data == {DATA_W{1'b1}})); // R6
  AST_DONE_ALONE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_kind == KIND_DONE |-> rsp_hdr && rsp_last); // R2
  AST_HDR_FIRST: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid ##1 rsp_valid |-> rsp_hdr); // R8
  AST_DATA_AFTER_HDR: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_hdr && rsp_ready && rsp_kind == KIND_READ |=> rsp_valid && !rsp_hdr); // R1
endmodule

// File: rtl/errrsp_top.sv
module errrsp_top
  import errrsp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 4,
  parameter int TAG_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_cmd,
  input  logic [CNT_W-1:0]  req_count,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic              req_tgt_fail,
  input  logic              req_no_claim,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hdr,
  output logic              rsp_kind,
  output logic              rsp_err,
  output logic              rsp_nxa,
  output logic [TAG_W-1:0]  rsp_tag,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_last
);
  job_t              job;
  logic [DATA_W-1:0] fill;
  logic              idle;
  logic              accept;

  assign req_ready = idle;
  assign accept    = req_valid & idle;

  errrsp_classify u_classify (
    .cmd      (req_cmd),
    .tgt_fail (req_tgt_fail),
    .no_claim (req_no_claim),
    .job      (job)
  );

  errrsp_filler #(.DATA_W(DATA_W)) u_filler (
    .nxa  (job.nxa),
    .fill (fill)
  );

  errrsp_sequencer #(.DATA_W(DATA_W), .CNT_W(CNT_W), .TAG_W(TAG_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .load      (accept),
    .job_in    (job),
    .count_in  (req_count),
    .tag_in    (req_tag),
    .fill_in   (fill),
    .idle      (idle),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_hdr   (rsp_hdr),
    .rsp_kind  (rsp_kind),
    .rsp_err   (rsp_err),
    .rsp_nxa   (rsp_nxa),
    .rsp_tag   (rsp_tag),
    .rsp_data  (rsp_data),
    .rsp_last  (rsp_last)
  );

  AST_NO_TAKE_BUSY: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !req_ready); // R10
  AST_POSTED_SILENT: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && req_cmd == CMD_WR_POSTED |=> !rsp_valid); // R9
  AST_TAG_COPY: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && (req_tgt_fail || req_no_claim) && req_cmd inside {[3'd1:3'd4]}
      |=> rsp_valid && rsp_hdr && rsp_tag == $past(req_tag)); // R7
endmodule

// File: tb/test_errrsp_top.sv
module test_errrsp_top;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 4;
  localparam int TAG_W  = 5;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [2:0]        req_cmd = '0;
  logic [CNT_W-1:0]  req_count = '0;
  logic [TAG_W-1:0]  req_tag = '0;
  logic              req_tgt_fail = 1'b0;
  logic              req_no_claim = 1'b0;
  logic              rsp_valid;
  logic              rsp_ready = 1'b0;
  logic              rsp_hdr;
  logic              rsp_kind;
  logic              rsp_err;
  logic              rsp_nxa;
  logic [TAG_W-1:0]  rsp_tag;
  logic [DATA_W-1:0] rsp_data;
  logic              rsp_last;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  errrsp_top #(.DATA_W(DATA_W), .CNT_W(CNT_W), .TAG_W(TAG_W)) i_errrsp_top (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_req(input logic [2:0] cmd, input int cnt, input int tag,
                          input logic tf, input logic nc);
    @(negedge clk);
    req_valid = 1'b1; req_cmd = cmd; req_count = CNT_W'(cnt); req_tag = TAG_W'(tag);
    req_tgt_fail = tf; req_no_claim = nc;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Collect one response; stall inserts backpressure every third cycle.
  task automatic collect(input string req, input logic kind, input logic nxa, input int tag,
                         input int ndata, input bit stall, input bit watch_ready);
    int beat = 0;
    int cyc = 0;
    logic [DATA_W-1:0] fillv = nxa ? '1 : '0;
    forever begin
      @(negedge clk);
      cyc++;
      rsp_ready = stall ? (cyc % 3 != 0) : 1'b1;
      if (watch_ready && rsp_valid) check({req, " R10 req_ready low"}, 64'(req_ready), 64'd0);
      if (cyc > 400) begin
        check({req, " response timeout"}, 64'(beat), 64'(ndata + 1));
        break;
      end
      if (rsp_valid && rsp_ready) begin
        if (beat == 0) begin
          check({req, " R8 header first"}, 64'(rsp_hdr), 64'd1);
          check({req, " R1/R2 kind"}, 64'(rsp_kind), 64'(kind));
          check({req, " R3/R4 err"}, 64'(rsp_err), 64'd1);
          check({req, " R3/R4 nxa"}, 64'(rsp_nxa), 64'(nxa));
        end else begin
          check({req, " R8 data beat not header"}, 64'(rsp_hdr), 64'd0);
          check({req, " R3/R6 filler"}, 64'(rsp_data), 64'(fillv));
        end
        check({req, " R7 tag"}, 64'(rsp_tag), 64'(tag));
        check({req, " R8 last flag"}, 64'(rsp_last), 64'(beat == ndata));
        beat++;
        if (rsp_last) break;
      end
    end
    check({req, " R5 beat count"}, 64'(beat), 64'(ndata + 1));
    @(posedge clk);
    #1 rsp_ready = 1'b0;
  endtask

  task automatic expect_silent(input string req, input logic [2:0] cmd, input logic tf, input logic nc);
    int seen = 0;
    send_req(cmd, 5, 9, tf, nc);
    rsp_ready = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (rsp_valid) seen++;
    end
    rsp_ready = 1'b0;
    check({req, " R9 no response"}, 64'(seen), 64'd0);
    check({req, " R9 still ready"}, 64'(req_ready), 64'd1);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R11 rsp_valid after reset", 64'(rsp_valid), 64'd0);
    check("R11 req_ready after reset", 64'(req_ready), 64'd1);
  endtask

  task automatic t_read_target_fail;
    send_req(3'd2, 3, 5, 1'b1, 1'b0);
    collect("read tgt fail R1 R3", 1'b0, 1'b0, 5, 4, 1'b0, 1'b0);
  endtask

  task automatic t_atomic_noclaim_stall;
    send_req(3'd3, 0, 17, 1'b1, 1'b1);
    collect("atomic noclaim R4 R6", 1'b0, 1'b1, 17, 1, 1'b1, 1'b0);
  endtask

  task automatic t_write_flush;
    send_req(3'd1, 7, 3, 1'b1, 1'b0);
    collect("np write R2", 1'b1, 1'b0, 3, 0, 1'b0, 1'b0);
    send_req(3'd4, 2, 30, 1'b0, 1'b1);
    collect("flush noclaim R2 R4", 1'b1, 1'b1, 30, 0, 1'b1, 1'b0);
  endtask

  task automatic t_long_read_stall;
    send_req(3'd2, 15, 31, 1'b0, 1'b1);
    collect("long read R5", 1'b0, 1'b1, 31, 16, 1'b1, 1'b0);
  endtask

  task automatic t_silent;
    expect_silent("posted write", 3'd0, 1'b1, 1'b1);
    expect_silent("reserved code", 3'd6, 1'b1, 1'b0);
    expect_silent("read no failure", 3'd2, 1'b0, 1'b0);
  endtask

  task automatic t_backpressure;
    send_req(3'd2, 2, 11, 1'b1, 1'b0);
    fork
      send_req(3'd3, 1, 22, 1'b0, 1'b1);
      collect("first of pair R10", 1'b0, 1'b0, 11, 3, 1'b1, 1'b1);
    join
    collect("queued second R10", 1'b0, 1'b1, 22, 2, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_read_target_fail();
    t_atomic_noclaim_stall();
    t_write_flush();
    t_long_read_stall();
    t_silent();
    t_backpressure();
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule